// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block turns one burst request into a stream of beat addresses. A master or a target hands it a start address, a beat count, a sequence kind and a flag that says whether the length is known. From the next cycle it presents one word-aligned address per beat. It moves to the next beat only when the consumer accepts the current one. Four orderings are supported: a linear run upward, a run that wraps inside an aligned block, a fixed address repeated on every beat, and an interleaved order formed by XOR with the beat index. One request phase therefore yields every address of the transaction.

When the length is known, the generator counts beats and raises the last flag on the final beat by itself. When the length is not known, the consumer supplies a remaining-beats hint with each beat, and the flag follows that hint. A second output shows the address of the beat after the current one, together with a valid bit. A target can use it to start a prefetch one beat ahead of demand.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high and in the cycle after it is released, `beat_valid_o`, `beat_last_o` and `ahead_valid_o` are all low.
- R2: A start strobe seen while no burst is active is taken at that clock edge. From the next cycle `beat_valid_o` is high and the first beat address is the start address with its low log2(WORD_BYTES) bits cleared.
- R3: Kind code 0 (incrementing): each accepted beat raises the next address by WORD_BYTES.
- R4: Kind code 1 (wrapping): the length must be a power of two. Addresses step up by WORD_BYTES and wrap inside the block of length×WORD_BYTES bytes that is aligned to its own size and holds the start address.
- R5: Kind code 2 (streaming): every beat carries the first beat address.
- R6: Kind code 3 (XOR): the length must be a power of two. The word index of beat k is the aligned block base ORed with ((start word index XOR k) modulo length).
- R7: When the known-length flag is 1, `beat_last_o` is high only on beat number `start_len_i`. Once that beat is accepted, `beat_valid_o` is low from the next cycle.
- R8: When the known-length flag is 0, `start_len_i` does not end the burst. `beat_last_o` equals (`remain_hint_i` == 1) during each beat, and accepting a beat while the hint is 1 ends the burst.
- R9: The generator advances only on a cycle with `beat_valid_o` and `beat_ready_i` both high. While `beat_ready_i` is low, the address and the valid flag hold.
- R10: A start strobe that arrives while a burst is active is ignored. The running burst keeps its addresses and its beat count.
- R11: `ahead_valid_o` is high while a further beat will follow the current one, and `ahead_addr_o` then equals the address the next beat will carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a new burst |
| start_addr_i | input | ADDR_W | Byte address of the first beat |
| start_len_i | input | LEN_W | Beat count (known length) or block length for wrap/XOR |
| start_kind_i | input | 2 | Sequence kind: 0 incr, 1 wrap, 2 stream, 3 XOR |
| start_precise_i | input | 1 | 1 = length known, 0 = length given by per-beat hint |
| remain_hint_i | input | LEN_W | Remaining beats including the current one (unknown-length bursts) |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | A beat address is presented |
| beat_addr_o | output | ADDR_W | Address of the current beat |
| beat_last_o | output | 1 | Current beat is the final one |
| ahead_valid_o | output | 1 | A beat follows the current one |
| ahead_addr_o | output | ADDR_W | Address of the following beat |

## Verification
A start strobe sampled at one rising edge makes the first address visible one register later, so the bench drives on the falling edge, lets one rising edge pass, and samples just after the next falling edge. Beat address and lookahead are combinational from the beat counter, so each accept moves them exactly one edge later, and each check is taken one falling edge after the accept it depends on. The last flag for unknown-length bursts follows the hint input within the same cycle, so it is checked right after the hint is driven and before the edge that consumes the beat. Stall and ignored-start cases are checked several edges after the stimulus, to show that nothing moved.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    // Address ordering selected at burst start
    typedef enum logic [1:0] {
        SEQ_INCR   = 2'd0,
        SEQ_WRAP   = 2'd1,
        SEQ_STREAM = 2'd2,
        SEQ_XOR    = 2'd3
    } seq_kind_e;

    // True when the ordering confines beats to a power-of-two block
    function automatic logic kind_is_blocked(input seq_kind_e k);
        return (k == SEQ_WRAP) || (k == SEQ_XOR);
    endfunction

endpackage

// File: rtl/burst_addr_map.sv
module burst_addr_map
    import burst_addr_pkg::*;
#(
    parameter int WIDX_W = 30,
    parameter int LEN_W  = 8
) (
    input  seq_kind_e          kind_i,
    input  logic [WIDX_W-1:0]  widx_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [LEN_W-1:0]   cnt_i,
    output logic [WIDX_W-1:0]  widx_o
);
    localparam int PAD_W = WIDX_W - LEN_W;

    logic [WIDX_W-1:0] len_x;
    logic [WIDX_W-1:0] cnt_x;
    logic [WIDX_W-1:0] mask;
    logic [WIDX_W-1:0] base;

    always_comb begin
        len_x = {{PAD_W{1'b0}}, len_i};
        cnt_x = {{PAD_W{1'b0}}, cnt_i};
        mask  = len_x - WIDX_W'(1);
        base  = widx_i & ~mask;
        case (kind_i)
            SEQ_INCR:   widx_o = widx_i + cnt_x;
            SEQ_WRAP:   widx_o = base | ((widx_i + cnt_x) & mask);
            SEQ_STREAM: widx_o = widx_i;
            SEQ_XOR:    widx_o = base | ((widx_i ^ cnt_x) & mask);
            default:    widx_o = widx_i;
        endcase
    end

endmodule

// File: rtl/burst_seq_ctl.sv
module burst_seq_ctl
    import burst_addr_pkg::*;
#(
    parameter int WIDX_W = 30,
    parameter int LEN_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  seq_kind_e          kind_i,
    input  logic               precise_i,
    input  logic [WIDX_W-1:0]  widx_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [LEN_W-1:0]   hint_i,
    input  logic               ready_i,
    output logic               active_o,
    output seq_kind_e          kind_o,
    output logic [WIDX_W-1:0]  widx_o,
    output logic [LEN_W-1:0]   len_o,
    output logic [LEN_W-1:0]   cnt_o,
    output logic               last_o,
    output logic               more_o
);
    typedef struct packed {
        seq_kind_e          kind;
        logic               precise;
        logic [WIDX_W-1:0]  widx;
        logic [LEN_W-1:0]   len;
    } burst_ctx_t;

    burst_ctx_t        ctx_q;
    logic              active_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [LEN_W:0]    cnt_nx;
    logic              accept;
    logic              hint_one;

    always_comb begin
        cnt_nx   = (LEN_W+1)'(cnt_q) + (LEN_W+1)'(1);
        accept   = active_q & ready_i;
        hint_one = (hint_i == LEN_W'(1));
        if (ctx_q.precise) begin
            last_o = active_q & (cnt_nx == {1'b0, ctx_q.len});
            more_o = active_q & (cnt_nx <  {1'b0, ctx_q.len});
        end else begin
            last_o = active_q & hint_one;
            more_o = active_q & ~hint_one;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
            ctx_q    <= '0;
        end else if (!active_q) begin
            if (start_i) begin
                active_q <= 1'b1;
                cnt_q    <= '0;
                ctx_q    <= '{kind: kind_i, precise: precise_i, widx: widx_i, len: len_i};
            end
        end else if (accept) begin
            if (last_o) active_q <= 1'b0;
            else        cnt_q    <= cnt_nx[LEN_W-1:0];
        end
    end

    assign active_o = active_q;
    assign kind_o   = ctx_q.kind;
    assign widx_o   = ctx_q.widx;
    assign len_o    = ctx_q.len;
    assign cnt_o    = cnt_q;

    // R2: an idle start launches a burst at beat zero
    a_r2_launch: assert property (@(posedge clk) disable iff (rst)
        !active_q && start_i |=> active_q && cnt_q == '0);

    // R10: a start during an active burst leaves the context untouched
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        active_q && start_i |=> $stable(ctx_q));

    // R4 / R6: block orderings need a power-of-two length
    a_r4_block_len_pow2: assert property (@(posedge clk) disable iff (rst)
        !active_q && start_i && kind_is_blocked(kind_i) |-> $countones(len_i) == 1);

    // R9: without a handshake the beat count holds
    a_r9_count_hold: assert property (@(posedge clk) disable iff (rst)
        active_q && !ready_i |=> active_q && $stable(cnt_q));

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  start_addr_i,
    input  logic [LEN_W-1:0]   start_len_i,
    input  logic [1:0]         start_kind_i,
    input  logic               start_precise_i,
    input  logic [LEN_W-1:0]   remain_hint_i,
    input  logic               beat_ready_i,
    output logic               beat_valid_o,
    output logic [ADDR_W-1:0]  beat_addr_o,
    output logic               beat_last_o,
    output logic               ahead_valid_o,
    output logic [ADDR_W-1:0]  ahead_addr_o
);
    localparam int OFS_W  = $clog2(WORD_BYTES);
    localparam int WIDX_W = ADDR_W - OFS_W;
    localparam int N_VIEW = 2;   // current beat and one beat ahead

    logic               active;
    seq_kind_e          kind;
    logic [WIDX_W-1:0]  widx;
    logic [LEN_W-1:0]   len;
    logic [LEN_W-1:0]   cnt;
    logic               last;
    logic               more;
    logic [WIDX_W-1:0]  widx_map [N_VIEW];

    burst_seq_ctl #(
        .WIDX_W (WIDX_W),
        .LEN_W  (LEN_W)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .kind_i    (seq_kind_e'(start_kind_i)),
        .precise_i (start_precise_i),
        .widx_i    (start_addr_i[ADDR_W-1:OFS_W]),
        .len_i     (start_len_i),
        .hint_i    (remain_hint_i),
        .ready_i   (beat_ready_i),
        .active_o  (active),
        .kind_o    (kind),
        .widx_o    (widx),
        .len_o     (len),
        .cnt_o     (cnt),
        .last_o    (last),
        .more_o    (more)
    );

    for (genvar g = 0; g < N_VIEW; g++) begin : g_view
        logic [LEN_W-1:0] cnt_g;
        assign cnt_g = cnt + LEN_W'(g);
        burst_addr_map #(
            .WIDX_W (WIDX_W),
            .LEN_W  (LEN_W)
        ) u_map (
            .kind_i (kind),
            .widx_i (widx),
            .len_i  (len),
            .cnt_i  (cnt_g),
            .widx_o (widx_map[g])
        );
    end

    assign beat_valid_o  = active;
    assign beat_last_o   = last;
    assign ahead_valid_o = more;
    assign beat_addr_o   = {widx_map[0], {OFS_W{1'b0}}};
    assign ahead_addr_o  = {widx_map[1], {OFS_W{1'b0}}};

    logic accept;
    assign accept = beat_valid_o && beat_ready_i;

    // R3: incrementing steps by one word per accepted beat
    a_r3_incr_step: assert property (@(posedge clk) disable iff (rst)
        accept && !beat_last_o && kind == SEQ_INCR
        |=> beat_addr_o == $past(beat_addr_o) + ADDR_W'(WORD_BYTES));

    // R5: streaming keeps one address
    a_r5_stream_fixed: assert property (@(posedge clk) disable iff (rst)
        accept && !beat_last_o && kind == SEQ_STREAM |=> $stable(beat_addr_o));

    // R7 / R8: accepting the final beat ends the burst
    a_r7_end_on_last: assert property (@(posedge clk) disable iff (rst)
        accept && beat_last_o |=> !beat_valid_o);

    // R9: a stalled beat holds its address
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o && !beat_ready_i |=> beat_valid_o && $stable(beat_addr_o));

    // R11: the lookahead address becomes the next beat address
    a_r11_ahead_match: assert property (@(posedge clk) disable iff (rst)
        accept && ahead_valid_o |=> beat_valid_o && beat_addr_o == $past(ahead_addr_o));

    // R11: no lookahead on a final beat
    a_r11_ahead_vs_last: assert property (@(posedge clk) disable iff (rst)
        beat_valid_o |-> !(ahead_valid_o && beat_last_o));

endmodule

// File: tb/test_burst_addr_gen.sv
`timescale 1ns/1ps
module test_burst_addr_gen;

    localparam int NV = 8;
    localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd1, 2'd0, 2'd3};
    localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h218, 32'h400, 32'h314,
                                           32'hFFC, 32'h50,  32'h203, 32'h2C};
    localparam int          V_LEN  [NV] = '{4, 4, 3, 8, 2, 1, 2, 2};
    localparam logic [31:0] V_E0   [NV] = '{32'h100, 32'h218, 32'h400, 32'h314,
                                           32'hFFC, 32'h50,  32'h200, 32'h2C};
    localparam logic [31:0] V_E1   [NV] = '{32'h104, 32'h21C, 32'h400, 32'h310,
                                           32'h1000, 32'h50, 32'h204, 32'h28};
    localparam logic [31:0] V_EL   [NV] = '{32'h10C, 32'h214, 32'h400, 32'h308,
                                           32'h1000, 32'h50, 32'h204, 32'h28};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [7:0]  start_len_i = '0;
    logic [1:0]  start_kind_i = '0;
    logic        start_precise_i = 1'b1;
    logic [7:0]  remain_hint_i = '0;
    logic        beat_ready_i = 1'b0;
    logic        beat_valid_o;
    logic [31:0] beat_addr_o;
    logic        beat_last_o;
    logic        ahead_valid_o;
    logic [31:0] ahead_addr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    burst_addr_gen i_burst_addr_gen (
        .clk             (clk),
        .rst             (rst),
        .start_i         (start_i),
        .start_addr_i    (start_addr_i),
        .start_len_i     (start_len_i),
        .start_kind_i    (start_kind_i),
        .start_precise_i (start_precise_i),
        .remain_hint_i   (remain_hint_i),
        .beat_ready_i    (beat_ready_i),
        .beat_valid_o    (beat_valid_o),
        .beat_addr_o     (beat_addr_o),
        .beat_last_o     (beat_last_o),
        .ahead_valid_o   (ahead_valid_o),
        .ahead_addr_o    (ahead_addr_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string kind_req(input logic [1:0] k);
        case (k)
            2'd0:    return "R3";
            2'd1:    return "R4";
            2'd2:    return "R5";
            default: return "R6";
        endcase
    endfunction

    // Strobe at a falling edge; return just after the next falling edge
    task automatic launch(input logic [1:0] k, input logic [31:0] a,
                          input int n, input logic precise);
        @(negedge clk);
        start_i         = 1'b1;
        start_kind_i    = k;
        start_addr_i    = a;
        start_len_i     = 8'(n);
        start_precise_i = precise;
        @(negedge clk);
        start_i = 1'b0;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "valid in reset", 32'(beat_valid_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk("R1", "valid after reset", 32'(beat_valid_o), 32'd0);
        chk("R1", "last after reset", 32'(beat_last_o), 32'd0);
        chk("R1", "ahead after reset", 32'(ahead_valid_o), 32'd0);

        // Table walk: known-length bursts of every kind
        for (int v = 0; v < NV; v++) begin
            launch(V_KIND[v], V_ADDR[v], V_LEN[v], 1'b1);
            chk("R2", "valid after start", 32'(beat_valid_o), 32'd1);
            for (int b = 0; b < V_LEN[v]; b++) begin
                beat_ready_i = 1'b1;
                #1;
                if (b == 0) chk("R2", "first address", beat_addr_o, V_E0[v]);
                if (b == 1) chk(kind_req(V_KIND[v]), "second address", beat_addr_o, V_E1[v]);
                if (b == V_LEN[v] - 1) begin
                    chk(kind_req(V_KIND[v]), "final address", beat_addr_o, V_EL[v]);
                    chk("R7", "last on final beat", 32'(beat_last_o), 32'd1);
                end else begin
                    chk("R7", "last before final", 32'(beat_last_o), 32'd0);
                end
                @(negedge clk);
            end
            beat_ready_i = 1'b0;
            #1;
            chk("R7", "idle after final", 32'(beat_valid_o), 32'd0);
        end

        // R9 stall, then R10 start while active
        launch(2'd0, 32'h600, 4, 1'b1);
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "valid held in stall", 32'(beat_valid_o), 32'd1);
        chk("R9", "address held in stall", beat_addr_o, 32'h600);
        launch(2'd2, 32'h900, 2, 1'b1);
        chk("R10", "address after ignored start", beat_addr_o, 32'h600);
        beat_ready_i = 1'b1;
        @(negedge clk);
        #1;
        chk("R10", "burst continues", beat_addr_o, 32'h604);
        repeat (3) @(negedge clk);
        beat_ready_i = 1'b0;
        #1;
        chk("R10", "burst ends at own length", 32'(beat_valid_o), 32'd0);

        // R8: unknown-length burst of 5 beats, length field 4 not used
        remain_hint_i = 8'd5;
        launch(2'd0, 32'h80, 4, 1'b0);
        for (int b = 0; b < 5; b++) begin
            remain_hint_i = 8'(5 - b);
            beat_ready_i  = 1'b1;
            #1;
            chk("R8", "address", beat_addr_o, 32'h80 + 32'(4 * b));
            chk("R8", "last follows hint", 32'(beat_last_o), (b == 4) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        beat_ready_i = 1'b0;
        #1;
        chk("R8", "idle after hint of one", 32'(beat_valid_o), 32'd0);

        // R11: lookahead on incrementing and wrapping bursts
        launch(2'd0, 32'h100, 2, 1'b1);
        chk("R11", "ahead valid", 32'(ahead_valid_o), 32'd1);
        chk("R11", "ahead address", ahead_addr_o, 32'h104);
        beat_ready_i = 1'b1;
        @(negedge clk);
        #1;
        chk("R11", "no ahead on final beat", 32'(ahead_valid_o), 32'd0);
        @(negedge clk);
        beat_ready_i = 1'b0;
        launch(2'd1, 32'h21C, 4, 1'b1);
        chk("R11", "wrap ahead address", ahead_addr_o, 32'h210);
        beat_ready_i = 1'b1;
        @(negedge clk);
        #1;
        chk("R11", "wrap next beat", beat_addr_o, 32'h210);
        repeat (3) @(negedge clk);
        beat_ready_i = 1'b0;
        #1;
        chk("R7", "idle after wrap burst", 32'(beat_valid_o), 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule